// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor's load/store port and a memory port one word wide. It keeps a small direct-mapped array of single-word lines. Each line stores a valid flag, a tag and one data word. A read that finds its word returns it in the same cycle without stalling. A read that misses stalls the processor, fetches the word from memory, installs it and then completes.

Every write goes to memory through a first-in first-out write buffer. The processor therefore continues at once and stalls only when that buffer is full. A write that finds its line also updates the cached word. A write that misses leaves the array untouched. A flush input drops every line at once. The processor is expected to hold its request steady while the stall output is high.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset no line is valid, `cpu_stall` is low while no request is present, and `mem_req` is low.
- R2: The low log2(LINES) bits of the word address select the line and the remaining upper bits form the tag. With the defaults (8 lines, 5-bit address), bits [2:0] are the index and bits [4:3] are the tag, so addresses 26 and 18 share a line and evict each other.
- R3: A read hits only when the selected line is valid and its tag matches. On a hit `cpu_stall` stays low and `cpu_rdata` carries the word in the same cycle.
- R4: On a read miss `cpu_stall` is high, a memory read (`mem_req`=1, `mem_we`=0) fetches the word, and the line is loaded with the new tag and marked valid. The stall drops in the cycle after the one in which `mem_ack` is sampled.
- R5: A write to a valid line whose tag matches updates the cached word, and the write is also sent to memory.
- R6: A write that misses allocates no line. Lines already held stay valid with their contents unchanged.
- R7: A write is accepted at the clock edge without a stall while the write buffer holds fewer than WB_DEPTH (default 4) entries. When the buffer is full, `cpu_stall` is high.
- R8: Buffered writes reach memory in the order they were issued, one entry per `mem_ack`.
- R9: A read miss does not start its memory fetch until the write buffer is empty, so it returns the latest word written to that address.
- R10: A one-cycle pulse on `flush` invalidates every line, so the next read to any address misses.
- R11: Once `mem_req` is raised, it stays high and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until `mem_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all lines |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while a read is not stalled |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory has completed the current access |

## Verification
A read hit is due in the cycle it is presented. The bench drives each request at a falling edge and samples `cpu_stall` and `cpu_rdata` one time step later, before the next rising edge. A read miss with an empty buffer holds the stall for the memory latency plus one cycle: one cycle to enter the fetch state, then the latency, after which the line is loaded at the edge that samples `mem_ack`. The bench counts stalled cycles and compares the count with that figure, or with a lower bound when a drain must come first. Writes are accepted at the first rising edge after they are driven. Their arrival in memory is checked only after the bench has waited for `mem_req` to fall.

// File: rtl/wtc_pkg.sv
// Shared types for the direct-mapped write-through cache.
package wtc_pkg;
    // Refill sequencer states.
    typedef enum logic [1:0] {
        RF_IDLE  = 2'd0,   // no read miss outstanding
        RF_DRAIN = 2'd1,   // read miss waiting for the write buffer to empty
        RF_FETCH = 2'd2    // memory read in flight
    } refill_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
// Line array of the cache: valid flags, tags and data words.
// Does: combinational lookup of one line; refill writes tag+data+valid;
//       write-hit updates data only; flush clears every valid flag.
// Assumes: LINES is a power of two; refill and update never coincide.
module wtc_tag_store #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int LINES  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [$clog2(LINES)-1:0]   look_idx,
    input  logic [ADDR_W-$clog2(LINES)-1:0] look_tag,
    output logic                       look_hit,
    output logic [DATA_W-1:0]          look_data,
    input  logic                       fill_en,
    input  logic [$clog2(LINES)-1:0]   fill_idx,
    input  logic [ADDR_W-$clog2(LINES)-1:0] fill_tag,
    input  logic [DATA_W-1:0]          fill_data,
    input  logic                       upd_en,
    input  logic [$clog2(LINES)-1:0]   upd_idx,
    input  logic [DATA_W-1:0]          upd_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid flags: cleared by reset and flush, set by refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    // Tag and data storage: refill loads both, write hit loads data.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (fill_en && (fill_idx == IDX_W'(i))) begin
                tag_q[i]  <= fill_tag;
                data_q[i] <= fill_data;
            end else if (upd_en && (upd_idx == IDX_W'(i))) begin
                data_q[i] <= upd_data;
            end
        end
    end

    // Lookup: hit needs valid line and matching tag.
    always_comb begin
        look_hit  = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
        look_data = data_q[look_idx];
    end
endmodule

// File: rtl/wtc_write_buffer.sv
// First-in first-out queue of pending memory writes.
// Does: push at tail, pop at head, both allowed in one cycle.
// Assumes: the caller never pushes when full nor pops when empty.
module wtc_write_buffer #(
    parameter int ENT_W = 37,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [ENT_W-1:0]             push_ent,
    input  logic                         pop,
    output logic [ENT_W-1:0]             head_ent,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ENT_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // Entry storage written at the tail.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_ent;
    end

    // Status and head view.
    always_comb begin
        head_ent = slot_q[rd_ptr_q];
        count    = count_q;
        full     = (count_q == FULL_CNT);
        empty    = (count_q == '0);
    end
endmodule

// File: rtl/wtc_refill_ctrl.sv
// Read-miss sequencer.
// Does: latches the missing address, waits for the write buffer to empty,
//       issues one memory read and loads the line when it is acknowledged.
// Assumes: no writes enter the buffer while it is busy (top blocks them).
module wtc_refill_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_rd,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              wb_empty,
    input  logic              mem_ack,
    output logic              busy,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fill_en
);
    refill_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    // State register and captured miss address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RF_IDLE && miss_rd) addr_q <= miss_addr;
        end
    end

    // Next state and fetch outputs.
    always_comb begin
        state_d   = state_q;
        fetch_req = 1'b0;
        fill_en   = 1'b0;
        unique case (state_q)
            RF_IDLE:  if (miss_rd) state_d = wb_empty ? RF_FETCH : RF_DRAIN;
            RF_DRAIN: if (wb_empty) state_d = RF_FETCH;
            RF_FETCH: begin
                fetch_req = 1'b1;
                if (mem_ack) begin
                    fill_en = 1'b1;
                    state_d = RF_IDLE;
                end
            end
            default:  state_d = RF_IDLE;
        endcase
        busy       = (state_q != RF_IDLE);
        fetch_addr = addr_q;
    end
endmodule

// File: rtl/dm_wt_cache.sv
// Direct-mapped, one-word-line, write-through cache with a write buffer.
// Does: read hits in zero wait cycles; read misses stall and refill after
//       the write buffer drains; writes queue to memory, stalling only
//       when the queue is full; write misses do not allocate; flush drops
//       all lines.
// Assumes: the CPU holds its request stable while cpu_stall is high;
//          memory keeps mem_rdata valid in the mem_ack cycle.
module dm_wt_cache #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int LINES    = 8,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int ENT_W = ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(WB_DEPTH + 1);

    logic [IDX_W-1:0]  cpu_idx, fill_idx;
    logic [TAG_W-1:0]  cpu_tag, fill_tag;
    logic              hit;
    logic [DATA_W-1:0] line_data;
    logic              rf_busy, fetch_req, fill_en;
    logic [ADDR_W-1:0] fetch_addr;
    logic              wr_accept, miss_rd, wb_pop;
    logic [ENT_W-1:0]  wb_head;
    logic [CNT_W-1:0]  wb_count;
    logic              wb_full, wb_empty;

    // Address split and CPU-side control.
    always_comb begin
        cpu_idx   = cpu_addr[IDX_W-1:0];
        cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
        fill_idx  = fetch_addr[IDX_W-1:0];
        fill_tag  = fetch_addr[ADDR_W-1:IDX_W];
        wr_accept = cpu_req && cpu_we && !wb_full && !rf_busy;
        miss_rd   = cpu_req && !cpu_we && !hit;
        cpu_stall = cpu_req && (cpu_we ? (wb_full || rf_busy) : !hit);
        cpu_rdata = line_data;
    end

    // Memory-side arbitration: buffered writes first, then the refill read.
    always_comb begin
        mem_we    = !wb_empty;
        mem_req   = !wb_empty || fetch_req;
        mem_addr  = wb_empty ? fetch_addr : wb_head[ENT_W-1:DATA_W];
        mem_wdata = wb_head[DATA_W-1:0];
        wb_pop    = mem_ack && !wb_empty;
    end

    wtc_tag_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .look_idx  (cpu_idx),
        .look_tag  (cpu_tag),
        .look_hit  (hit),
        .look_data (line_data),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_tag  (fill_tag),
        .fill_data (mem_rdata),
        .upd_en    (wr_accept && hit),
        .upd_idx   (cpu_idx),
        .upd_data  (cpu_wdata)
    );

    wtc_write_buffer #(.ENT_W(ENT_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_accept),
        .push_ent ({cpu_addr, cpu_wdata}),
        .pop      (wb_pop),
        .head_ent (wb_head),
        .count    (wb_count),
        .full     (wb_full),
        .empty    (wb_empty)
    );

    wtc_refill_ctrl #(.ADDR_W(ADDR_W)) u_refill (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_rd    (miss_rd),
        .miss_addr  (cpu_addr),
        .wb_empty   (wb_empty),
        .mem_ack    (mem_ack && wb_empty),
        .busy       (rf_busy),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fill_en    (fill_en)
    );
endmodule

// File: rtl/wtc_checker.sv
// Protocol and ordering properties for dm_wt_cache, bound to every instance.
module wtc_checker #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 32,
    parameter int WB_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           flush,
    input logic                           cpu_req,
    input logic                           cpu_we,
    input logic [ADDR_W-1:0]              cpu_addr,
    input logic                           cpu_stall,
    input logic                           mem_req,
    input logic                           mem_we,
    input logic [ADDR_W-1:0]              mem_addr,
    input logic [DATA_W-1:0]              mem_wdata,
    input logic                           mem_ack,
    input logic [$clog2(WB_DEPTH+1)-1:0]  wb_count
);
    localparam int CNT_W = $clog2(WB_DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WB_DEPTH);

    // R1: no memory traffic in the first cycle out of reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req);

    // R4: the stall of a held read is released right after the refill ack.
    a_r4_refill_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_stall && mem_ack && !mem_we && !flush)
        |=> (!(cpu_req && !cpu_we && $stable(cpu_addr)) || !cpu_stall));

    // R7: a write meeting a full buffer is stalled.
    a_r7_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && wb_count == FULL_CNT) |-> cpu_stall);

    // R8: occupancy never exceeds the depth.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wb_count <= FULL_CNT);

    // R8: a write acknowledge never raises occupancy.
    a_r8_one_per_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_we) |=> wb_count <= $past(wb_count));

    // R11: a pending memory request holds its command until acknowledged.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind dm_wt_cache wtc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)
) u_wtc_checker (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .wb_count(wb_count)
);

// File: tb/test_dm_wt_cache.sv
// Directed bench for dm_wt_cache with a behavioural word memory.
module test_dm_wt_cache;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_stall;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int cnt = 0;
    int last_stalls = 0;
    bit last_stall_first = 0;
    logic [DW-1:0] mem_img [32];
    logic [DW-1:0] exp_mem [32];
    logic [AW-1:0] log_addr [64];
    int log_n = 0;
    bit pend = 0;
    logic [AW-1:0] pend_addr;
    logic pend_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_wt_cache i_dm_wt_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: acknowledges after lat falling edges; also checks R11.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            cnt = 0;
            pend = 0;
        end else if (mem_req) begin
            if (pend)
                check(mem_addr == pend_addr && mem_we == pend_we, "R11 hold",
                      {27'd0, mem_addr}, {27'd0, pend_addr});
            pend = 1; pend_addr = mem_addr; pend_we = mem_we;
            cnt++;
            if (cnt >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem_img[mem_addr] = mem_wdata;
                    log_addr[log_n] = mem_addr;
                    log_n++;
                end else begin
                    mem_rdata = mem_img[mem_addr];
                end
            end
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input bit exp_hit, input string req);
        bit got_hit;
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        #1;
        got_hit = !cpu_stall;
        last_stalls = 0;
        while (cpu_stall) begin
            last_stalls++;
            @(negedge clk); #1;
        end
        check(got_hit == exp_hit, {req, " hit"}, {31'd0, got_hit}, {31'd0, exp_hit});
        check(cpu_rdata == exp_mem[a], {req, " data"}, cpu_rdata, exp_mem[a]);
        @(posedge clk); #1;
        cpu_req = 0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        #1;
        last_stall_first = cpu_stall;
        while (cpu_stall) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;
        exp_mem[a] = d;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (mem_req || mem_ack) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check(cpu_stall == 1'b0, "R1 stall", {31'd0, cpu_stall}, 0);
        check(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 0);
    endtask

    task automatic t_sequence();
        logic [AW-1:0] seq [8] = '{5'd22, 5'd26, 5'd22, 5'd26, 5'd16, 5'd3, 5'd16, 5'd18};
        bit            hits [8] = '{0, 0, 1, 1, 0, 0, 1, 0};
        lat = 1;
        for (int i = 0; i < 8; i++) begin
            do_read(seq[i], hits[i], hits[i] ? "R3 seq" : "R4 seq");
            if (i == 0)
                check(last_stalls == lat + 1, "R4 stall cycles", last_stalls, lat + 1);
        end
        do_read(5'd18, 1, "R2 index 010 now 18");
        do_read(5'd26, 0, "R2 26 evicted by 18");
        do_read(5'd3, 1, "R1 other lines kept");
    endtask

    task automatic t_write_hit();
        lat = 1;
        do_write(5'd22, 32'hAAAA_0022);
        check(last_stall_first == 0, "R7 no stall", {31'd0, last_stall_first}, 0);
        do_read(5'd22, 1, "R5 updated line");
        wait_idle();
        check(mem_img[22] == 32'hAAAA_0022, "R5 memory written", mem_img[22], 32'hAAAA_0022);
    endtask

    task automatic t_write_miss();
        lat = 1;
        do_write(5'd30, 32'hBBBB_0030);
        wait_idle();
        do_read(5'd22, 1, "R6 line not replaced");
        do_read(5'd30, 0, "R6 no allocate");
    endtask

    task automatic t_fifo();
        int base;
        lat = 6;
        base = log_n;
        for (int i = 0; i < 5; i++) begin
            do_write(AW'(8 + i), 32'hC000_0000 + i);
            check(last_stall_first == (i == 4), "R7 full stall",
                  {31'd0, last_stall_first}, {31'd0, i == 4});
        end
        wait_idle();
        check(log_n - base == 5, "R8 write count", log_n - base, 5);
        for (int i = 0; i < 5; i++)
            check(log_addr[base + i] == AW'(8 + i), "R8 order",
                  {27'd0, log_addr[base + i]}, 8 + i);
    endtask

    task automatic t_raw();
        lat = 8;
        do_write(5'd5, 32'hDDDD_0005);
        do_read(5'd5, 0, "R9 read after buffered write");
        check(last_stalls >= 2 * lat, "R9 waited for drain", last_stalls, 2 * lat);
    endtask

    task automatic t_flush();
        lat = 1;
        wait_idle();
        do_read(5'd16, 1, "R10 before flush");
        @(negedge clk); flush = 1;
        @(posedge clk); #1; flush = 0;
        do_read(5'd16, 0, "R10 after flush");
        do_read(5'd3, 0, "R10 after flush other line");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem_img[i] = 32'h5EED_0000 + 32'(i * 17);
            exp_mem[i] = mem_img[i];
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sequence();
        t_write_hit();
        t_write_miss();
        t_fifo();
        t_raw();
        t_flush();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule